// File: doc/BRIEF.md
# Packed Lane Blend Unit

This execution unit assembles an output vector of 64-bit lanes, choosing each lane from one of two source vectors under the control of an 8-bit immediate byte. It sits in a vector pipeline after operand fetch. Each cycle it may take one operation: a 512-bit copy of the destination's previous contents, two 256-bit sources, the control byte and a form select. One clock later it delivers a 512-bit result with a valid flag.

Three forms are supported. The legacy 128-bit form blends into the old destination value and keeps everything above bit 127. The two VEX forms blend two or four lanes from the two sources and clear every bit above the last lane they process. Lane contents are copied bit-for-bit. No floating-point meaning is applied, so no exception flags exist.

Top module: `lane_blend_unit`

## Requirements
- R1: In the VEX forms, lane n of the result (bits 64n+63 down to 64n) comes from lane n of `src_a` when `ctrl[n]` is 0, and from lane n of `src_b` when `ctrl[n]` is 1.
- R2: In the legacy form (`form_sel` = 0), result lanes 0 and 1 come from `dst_old` when the matching control bit is 0, and from `src_b` when it is 1. `src_a` has no effect in this form.
- R3: In the legacy form, result bits 511:128 equal bits 511:128 of `dst_old`.
- R4: In the VEX 128-bit form (`form_sel` = 1), lanes 0 and 1 are blended and result bits 511:128 are zero.
- R5: In the VEX 256-bit form (`form_sel` = 2), lanes 0 to 3 are blended with control bits 0 to 3, and result bits 511:256 are zero.
- R6: Control bits 7:4 have no effect in any form. Control bits 3:2 have no effect in the two 128-bit forms.
- R7: `form_sel` = 3 is reserved. It yields an all-zero result, and `out_valid` is still asserted.
- R8: `result` and `out_valid` appear exactly one clock after `in_valid`. An operation can be accepted every cycle, and `out_valid` is low one clock after a cycle with `in_valid` low.
- R9: A synchronous active-high `rst` clears `out_valid`, even when `in_valid` is high during reset.
- R10: Lane data moves unaltered, including NaN, denormal and arbitrary integer bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| form_sel | input | 2 | 0 legacy 128, 1 VEX 128, 2 VEX 256, 3 reserved |
| ctrl | input | 8 | Immediate lane-select byte |
| dst_old | input | 512 | Previous destination contents |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 512 | Blended result |

## Verification
The bench runs every control byte under every form, back to back. This shows that control bits are ignored where they should be: a unit reading bit 2 or 3 in a 128-bit form, or bits 4 to 7 anywhere, would corrupt lanes that the bench expects untouched.

Source data differs in every lane and includes NaN and denormal patterns. A unit that took lanes from the wrong source, for example `src_a` in the legacy form, would be caught. So would one that shifted lanes or altered payloads. The upper-bit rule is checked per form: a VEX form that leaked old destination bits would fail, and so would a legacy form that cleared them. The bench also checks the reserved encoding, and valid timing around bubbles and reset.

// File: rtl/lane_blend_unit.sv
module lane_blend_unit #(
  parameter int LANE_W       = 64,
  parameter int SRC_LANES    = 4,
  parameter int DST_LANES    = 8,
  parameter int NARROW_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [1:0]                  form_sel,
  input  logic [7:0]                  ctrl,
  input  logic [LANE_W*DST_LANES-1:0] dst_old,
  input  logic [LANE_W*SRC_LANES-1:0] src_a,
  input  logic [LANE_W*SRC_LANES-1:0] src_b,
  output logic                        out_valid,
  output logic [LANE_W*DST_LANES-1:0] result
);

  localparam int DST_W    = LANE_W * DST_LANES;
  localparam int SRC_W    = LANE_W * SRC_LANES;
  localparam int NARROW_W = LANE_W * NARROW_LANES;

  localparam logic [1:0] FORM_LEG  = 2'd0;
  localparam logic [1:0] FORM_V128 = 2'd1;
  localparam logic [1:0] FORM_V256 = 2'd2;

  logic [DST_W-1:0] blend;

  for (genvar i = 0; i < DST_LANES; i++) begin : g_lane
    logic [LANE_W-1:0] old_l;
    assign old_l = dst_old[i*LANE_W +: LANE_W];
    if (i < SRC_LANES) begin : g_src
      logic [LANE_W-1:0] a_l, b_l;
      assign a_l = src_a[i*LANE_W +: LANE_W];
      assign b_l = src_b[i*LANE_W +: LANE_W];
      if (i < NARROW_LANES) begin : g_narrow
        assign blend[i*LANE_W +: LANE_W] =
          (form_sel == FORM_LEG)                          ? (ctrl[i] ? b_l : old_l) :
          (form_sel == FORM_V128 || form_sel == FORM_V256) ? (ctrl[i] ? b_l : a_l)   :
          '0;
      end else begin : g_wide
        assign blend[i*LANE_W +: LANE_W] =
          (form_sel == FORM_LEG)  ? old_l :
          (form_sel == FORM_V256) ? (ctrl[i] ? b_l : a_l) :
          '0;
      end
    end else begin : g_upper
      assign blend[i*LANE_W +: LANE_W] = (form_sel == FORM_LEG) ? old_l : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) result <= blend;
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_legacy_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_LEG) |=> result[DST_W-1:NARROW_W] == $past(dst_old[DST_W-1:NARROW_W]));
  assert_v128_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_V128) |=> result[DST_W-1:NARROW_W] == '0);
  assert_v256_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_V256) |=> result[DST_W-1:SRC_W] == '0);
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == 2'd3) |=> (result == '0 && out_valid));
  assert_lane0_pick_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == FORM_V256) |=>
      result[LANE_W-1:0] == ($past(ctrl[0]) ? $past(src_b[LANE_W-1:0]) : $past(src_a[LANE_W-1:0])));

endmodule

// File: tb/tb_lane_blend_unit.sv
module tb_lane_blend_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   form_sel = '0;
  logic [7:0]   ctrl = '0;
  logic [511:0] dst_old = '0;
  logic [255:0] src_a = '0;
  logic [255:0] src_b = '0;
  logic         out_valid;
  logic [511:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lane_blend_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel), .ctrl(ctrl),
    .dst_old(dst_old), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [511:0] model(input logic [1:0] f, input logic [7:0] c,
      input logic [511:0] d, input logic [255:0] a, input logic [255:0] b);
    logic [511:0] r;
    int n_lanes;
    r = '0;
    n_lanes = (f == 2'd2) ? 4 : 2;
    if (f == 2'd0) r = d;
    if (f != 2'd3) begin
      for (int n = 0; n < n_lanes; n++) begin
        if (c[n])           r[n*64 +: 64] = b[n*64 +: 64];
        else if (f == 2'd0) r[n*64 +: 64] = d[n*64 +: 64];
        else                r[n*64 +: 64] = a[n*64 +: 64];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] pattern(input int k);
    case (k % 5)
      0: return 64'h7FF8_0000_0000_0001;
      1: return 64'h0000_0000_0000_0001;
      2: return 64'hFFF0_0000_0000_0000;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  task automatic load_data(input int seed);
    for (int n = 0; n < 8; n++) dst_old[n*64 +: 64] = pattern(seed + n) ^ (64'h1 << n);
    for (int n = 0; n < 4; n++) begin
      src_a[n*64 +: 64] = pattern(seed + 3*n + 1) ^ (64'h100 << n);
      src_b[n*64 +: 64] = pattern(seed + 7*n + 2) ^ (64'h10000 << n);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp;
    string tag;
    // R9: reset holds valid low even with in_valid high
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R9 reset clears out_valid", out_valid, 1'b0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_bit("R8 idle after reset", out_valid, 1'b0);

    // Full sweep of forms and control bytes, back to back (R1..R8, R10)
    for (int f = 0; f < 4; f++) begin
      for (int c = 0; c < 256; c++) begin
        form_sel = f[1:0];
        ctrl = c[7:0];
        load_data(f * 256 + c);
        in_valid = 1'b1;
        exp = model(form_sel, ctrl, dst_old, src_a, src_b);
        case (f)
          0: tag = "R2 R3 R6 R10 legacy";
          1: tag = "R1 R4 R6 R10 vex128";
          2: tag = "R1 R5 R6 R10 vex256";
          default: tag = "R7 reserved";
        endcase
        @(negedge clk);
        check_bit({tag, " R8 valid"}, out_valid, 1'b1);
        check_vec(tag, result, exp);
      end
    end

    // R2: src_a has no effect in legacy form
    form_sel = 2'd0; ctrl = 8'h00; load_data(9);
    exp = model(2'd0, 8'h00, dst_old, src_a, src_b);
    src_a = ~src_a;
    @(negedge clk);
    check_vec("R2 src_a ignored in legacy", result, exp);

    // R6: high bits ignored, compared against the masked byte
    form_sel = 2'd2; ctrl = 8'hF5; load_data(11);
    exp = model(2'd2, 8'h05, dst_old, src_a, src_b);
    @(negedge clk);
    check_vec("R6 bits 7:4 ignored vex256", result, exp);
    form_sel = 2'd1; ctrl = 8'h0E;
    exp = model(2'd1, 8'h02, dst_old, src_a, src_b);
    @(negedge clk);
    check_vec("R6 bits 3:2 ignored vex128", result, exp);

    // R8: bubble drops valid
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R8 bubble", out_valid, 1'b0);
    in_valid = 1'b1; form_sel = 2'd3;
    @(negedge clk);
    check_bit("R7 reserved still valid", out_valid, 1'b1);
    check_vec("R7 reserved zero", result, '0);

    // R9: reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    check_bit("R9 mid-run reset", out_valid, 1'b0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check_bit("R8 idle after second reset", out_valid, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule